// File: doc/BRIEF.md
# Toggle-Qualified Configuration Shadow Capture

This block keeps a local copy of configuration state in an application clock domain that is not related to the core clock. On the core side, a stream of register snapshots arrives one at a time. Each snapshot is a 4-bit register index paired with a 32-bit data word. A separate 53-bit status word also arrives. Each of the two streams has its own qualifier, and that qualifier changes level once for every new value. A rising edge and a falling edge both mean new data. The source holds each value stable for 8 core clock cycles.

The block registers the core-side inputs in the core clock. It then passes each qualifier through a two-flop synchronizer and an XOR edge detector into the application clock. Each detected edge drives a capture state machine. The control channel writes a 16-entry shadow register file, and each entry has a valid flag. The status channel writes a status register whose fields are also decoded onto separate outputs. The data is sampled straight from the core-side registers without a FIFO. This works because the synchronizer delay plus one cycle is much shorter than the 8-cycle hold window.

Each channel has its own capture state machine with three states:
- `CAP_PRIME` is entered on reset. It counts `SYNC_STAGES+1` application cycles so that the synchronizer can fill, and it ignores any edges seen in that time. It then moves to `CAP_IDLE`.
- `CAP_IDLE` waits for an edge. When an edge is detected, it moves to `CAP_WRITE`.
- `CAP_WRITE` raises the write enable for one cycle. It returns to `CAP_IDLE`, or it stays in `CAP_WRITE` if another edge is already present.

Top module: `cfg_shadow_capture`

## Requirements
- R1: After reset, every shadow entry reads data 0 with valid 0, and the status word and all decoded status fields are 0.
- R2: Each change of level on `src_ctl_tgl` (0 to 1 or 1 to 0) writes the `src_idx`/`src_data` pair into the shadow entry at that index and sets that entry's valid bit.
- R3: A control capture leaves every other shadow entry's data and valid bit unchanged, and a valid bit never clears again until reset.
- R4: The read port is combinational. `rd_data`/`rd_valid` show the entry selected by `rd_idx` in the same application cycle.
- R5: Each change of level on `src_sts_tgl` copies the 53-bit `src_sts` into `sts_word`.
- R6: The decoded fields come from `sts_word` as follows:
  - `sts_err_rpt_en`[3:0] = bits 52:49. Bit 3 is correctable, bit 2 is non-fatal, bit 1 is fatal and bit 0 is unsupported-request.
  - `sts_dll_chg` = bit 48.
  - `sts_cmd_done` = bit 47.
  - `sts_link` = bits 46:31.
  - `sts_deemph` = bit 30.
  - `sts_prim_err` = bits 29:24.
  - `sts_pme` = bits 23:6.
  - `sts_sec_err` = bits 5:0.
- R7: A change on `src_idx`, `src_data` or `src_sts` with no change on its qualifier alters neither the shadow file nor the status word.
- R8: The two channels are independent. A control update never changes `sts_word`, and a status update never changes the shadow file.
- R9: Each qualifier change produces exactly one single-cycle internal write enable in the application domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Core clock |
| src_rst_n | input | 1 | Core-side active-low asynchronous reset |
| src_idx | input | 4 | Register index of the current snapshot |
| src_data | input | 32 | Data word of the current snapshot |
| src_ctl_tgl | input | 1 | Control qualifier; either edge marks a new pair |
| src_sts | input | 53 | Status snapshot |
| src_sts_tgl | input | 1 | Status qualifier; either edge marks new status |
| app_clk | input | 1 | Application clock |
| app_rst_n | input | 1 | Application-side active-low asynchronous reset |
| rd_idx | input | 4 | Shadow read index |
| rd_data | output | 32 | Shadow word at `rd_idx` |
| rd_valid | output | 1 | Entry at `rd_idx` has been written since reset |
| sts_word | output | 53 | Captured status word |
| sts_err_rpt_en | output | 4 | Error-reporting enables (corr, non-fatal, fatal, UR) |
| sts_dll_chg | output | 1 | Data-link-state-changed flag |
| sts_cmd_done | output | 1 | Command-completed flag |
| sts_link | output | 16 | Link status bits |
| sts_deemph | output | 1 | Current de-emphasis level |
| sts_prim_err | output | 6 | Primary error bits |
| sts_pme | output | 18 | PME-related bits |
| sts_sec_err | output | 6 | Secondary error bits |

## Verification
The single-cycle enable property and the valid-after-write property both assume two things about the inputs:
- Qualifier edges on one channel arrive no closer together than the 8-core-cycle update period.
- The index and data stay stable for that whole period.

The stimulus meets both conditions. It changes data and qualifier together on a core-clock falling edge and then holds them for eight full core cycles. It also runs the core clock at 50 MHz against the 250 MHz application clock. The bench checks that this clock ratio leaves the synchronizer latency well inside the hold window. Both qualifiers stay low through reset, so the priming window never has an edge to discard.

// File: rtl/cfgsh_pkg.sv
package cfgsh_pkg;

    localparam int STS_W = 53;

    typedef enum logic [1:0] {
        CAP_PRIME = 2'd0,
        CAP_IDLE  = 2'd1,
        CAP_WRITE = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic [3:0]  err_rpt_en;
        logic        dll_chg;
        logic        cmd_done;
        logic [15:0] link;
        logic        deemph;
        logic [5:0]  prim_err;
        logic [17:0] pme;
        logic [5:0]  sec_err;
    } sts_fields_t;

endpackage

// File: rtl/cfgsh_tgl_sync.sv
module cfgsh_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic edge_pulse
);
    // chain[STAGES-1:0] synchronise, chain[STAGES] is the delayed copy
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], tgl_in};
        end
    end

    assign edge_pulse = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/cfgsh_cap_fsm.sv
module cfgsh_cap_fsm
    import cfgsh_pkg::*;
#(
    parameter int PRIME_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_in,
    output logic wr_en
);
    localparam int CW = $clog2(PRIME_CYCLES + 1);
    localparam logic [CW-1:0] PRIME_LAST = CW'(PRIME_CYCLES - 1);

    cap_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q;

    // state register and priming counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_PRIME;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == CAP_PRIME) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_PRIME: if (cnt_q == PRIME_LAST) state_d = CAP_IDLE;
            CAP_IDLE:  if (edge_in)             state_d = CAP_WRITE;
            CAP_WRITE: state_d = edge_in ? CAP_WRITE : CAP_IDLE;
            default:   state_d = CAP_PRIME;
        endcase
    end

    // outputs
    always_comb begin
        wr_en = 1'b0;
        unique case (state_q)
            CAP_WRITE: wr_en = 1'b1;
            default:   wr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfgsh_shadow_rf.sv
module cfgsh_shadow_rf #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [(1<<IDX_W)-1:0] vld_all
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] words [DEPTH];
    logic [DEPTH-1:0]  vld;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic [DATA_W-1:0] word_q;
        logic              vld_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
                vld_q  <= 1'b0;
            end else if (we && (widx == IDX_W'(e))) begin
                word_q <= wdata;
                vld_q  <= 1'b1;
            end
        end
        assign words[e] = word_q;
        assign vld[e]   = vld_q;
    end

    assign rdata   = words[ridx];
    assign rvalid  = vld[ridx];
    assign vld_all = vld;

endmodule

// File: rtl/cfgsh_sts_decode.sv
module cfgsh_sts_decode
    import cfgsh_pkg::*;
(
    input  logic [STS_W-1:0] word,
    output sts_fields_t      fields
);
    always_comb begin
        fields.err_rpt_en = word[52:49];
        fields.dll_chg    = word[48];
        fields.cmd_done   = word[47];
        fields.link       = word[46:31];
        fields.deemph     = word[30];
        fields.prim_err   = word[29:24];
        fields.pme        = word[23:6];
        fields.sec_err    = word[5:0];
    end

endmodule

// File: rtl/cfg_shadow_capture.sv
module cfg_shadow_capture
    import cfgsh_pkg::*;
#(
    parameter int IDX_W       = 4,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_ctl_tgl,
    input  logic [STS_W-1:0]  src_sts,
    input  logic              src_sts_tgl,
    input  logic              app_clk,
    input  logic              app_rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [STS_W-1:0]  sts_word,
    output logic [3:0]        sts_err_rpt_en,
    output logic              sts_dll_chg,
    output logic              sts_cmd_done,
    output logic [15:0]       sts_link,
    output logic              sts_deemph,
    output logic [5:0]        sts_prim_err,
    output logic [17:0]       sts_pme,
    output logic [5:0]        sts_sec_err
);
    localparam int PRIME_CYCLES = SYNC_STAGES + 1;
    localparam int DEPTH        = 1 << IDX_W;

    // core-domain holding registers
    logic [IDX_W-1:0]  src_idx_q;
    logic [DATA_W-1:0] src_data_q;
    logic              src_ctl_tgl_q;
    logic [STS_W-1:0]  src_sts_q;
    logic              src_sts_tgl_q;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            src_idx_q     <= '0;
            src_data_q    <= '0;
            src_ctl_tgl_q <= 1'b0;
            src_sts_q     <= '0;
            src_sts_tgl_q <= 1'b0;
        end else begin
            src_idx_q     <= src_idx;
            src_data_q    <= src_data;
            src_ctl_tgl_q <= src_ctl_tgl;
            src_sts_q     <= src_sts;
            src_sts_tgl_q <= src_sts_tgl;
        end
    end

    // application-domain crossing and capture control
    logic ctl_edge, sts_edge;
    logic ctl_we, sts_we;

    cfgsh_tgl_sync #(.STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk(app_clk), .rst_n(app_rst_n), .tgl_in(src_ctl_tgl_q), .edge_pulse(ctl_edge)
    );
    cfgsh_tgl_sync #(.STAGES(SYNC_STAGES)) u_sts_sync (
        .clk(app_clk), .rst_n(app_rst_n), .tgl_in(src_sts_tgl_q), .edge_pulse(sts_edge)
    );
    cfgsh_cap_fsm #(.PRIME_CYCLES(PRIME_CYCLES)) u_ctl_fsm (
        .clk(app_clk), .rst_n(app_rst_n), .edge_in(ctl_edge), .wr_en(ctl_we)
    );
    cfgsh_cap_fsm #(.PRIME_CYCLES(PRIME_CYCLES)) u_sts_fsm (
        .clk(app_clk), .rst_n(app_rst_n), .edge_in(sts_edge), .wr_en(sts_we)
    );

    // shadow file
    logic [DEPTH-1:0] rf_valid;

    cfgsh_shadow_rf #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rf (
        .clk(app_clk), .rst_n(app_rst_n),
        .we(ctl_we), .widx(src_idx_q), .wdata(src_data_q),
        .ridx(rd_idx), .rdata(rd_data), .rvalid(rd_valid),
        .vld_all(rf_valid)
    );

    // status register
    logic [STS_W-1:0] sts_q;

    always_ff @(posedge app_clk or negedge app_rst_n) begin
        if (!app_rst_n) begin
            sts_q <= '0;
        end else if (sts_we) begin
            sts_q <= src_sts_q;
        end
    end

    sts_fields_t sts_f;

    cfgsh_sts_decode u_dec (.word(sts_q), .fields(sts_f));

    assign sts_word       = sts_q;
    assign sts_err_rpt_en = sts_f.err_rpt_en;
    assign sts_dll_chg    = sts_f.dll_chg;
    assign sts_cmd_done   = sts_f.cmd_done;
    assign sts_link       = sts_f.link;
    assign sts_deemph     = sts_f.deemph;
    assign sts_prim_err   = sts_f.prim_err;
    assign sts_pme        = sts_f.pme;
    assign sts_sec_err    = sts_f.sec_err;

endmodule

// File: rtl/cfgsh_checker.sv
module cfgsh_checker #(
    parameter int IDX_W = 4,
    parameter int STS_W = 53
) (
    input logic                   app_clk,
    input logic                   app_rst_n,
    input logic                   ctl_we,
    input logic                   sts_we,
    input logic [IDX_W-1:0]       ctl_widx,
    input logic [(1<<IDX_W)-1:0]  rf_valid,
    input logic [STS_W-1:0]       sts_word
);
    // R9: one write enable per qualifier change
    a_r9_ctl_single: assert property (@(posedge app_clk) disable iff (!app_rst_n)
        ctl_we |=> !ctl_we);
    a_r9_sts_single: assert property (@(posedge app_clk) disable iff (!app_rst_n)
        sts_we |=> !sts_we);

    // R2: captured index becomes valid
    a_r2_valid_set: assert property (@(posedge app_clk) disable iff (!app_rst_n)
        ctl_we |=> rf_valid[$past(ctl_widx)]);

    // R3: valid bits never clear
    a_r3_valid_sticky: assert property (@(posedge app_clk) disable iff (!app_rst_n)
        ##1 ((rf_valid & $past(rf_valid)) == $past(rf_valid)));

    // R7: no write enable, no valid change
    a_r7_valid_hold: assert property (@(posedge app_clk) disable iff (!app_rst_n)
        !ctl_we |=> $stable(rf_valid));

    // R5: status word only moves on a status write
    a_r5_sts_hold: assert property (@(posedge app_clk) disable iff (!app_rst_n)
        !sts_we |=> $stable(sts_word));

endmodule

bind cfg_shadow_capture cfgsh_checker #(.IDX_W(IDX_W), .STS_W(cfgsh_pkg::STS_W)) u_chk (
    .app_clk  (app_clk),
    .app_rst_n(app_rst_n),
    .ctl_we   (ctl_we),
    .sts_we   (sts_we),
    .ctl_widx (src_idx_q),
    .rf_valid (rf_valid),
    .sts_word (sts_word)
);

// File: tb/tb_cfg_shadow_capture.sv
module tb_cfg_shadow_capture;

    localparam int APP_HALF = 2;   // 250 MHz
    localparam int SRC_HALF = 10;  // 50 MHz
    localparam int SYNC     = 2;

    logic        src_clk = 0, app_clk = 0;
    logic        src_rst_n = 0, app_rst_n = 0;
    logic [3:0]  src_idx = 0;
    logic [31:0] src_data = 0;
    logic        src_ctl_tgl = 0;
    logic [52:0] src_sts = 0;
    logic        src_sts_tgl = 0;
    logic [3:0]  rd_idx = 0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [52:0] sts_word;
    logic [3:0]  sts_err_rpt_en;
    logic        sts_dll_chg, sts_cmd_done, sts_deemph;
    logic [15:0] sts_link;
    logic [5:0]  sts_prim_err, sts_sec_err;
    logic [17:0] sts_pme;

    int checks = 0, errors = 0;
    logic        done = 0;
    logic [31:0] exp_data [16];
    logic        exp_vld  [16];
    logic [52:0] exp_sts;

    always #(APP_HALF) app_clk = ~app_clk;
    always #(SRC_HALF) src_clk = ~src_clk;

    cfg_shadow_capture dut (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_entry(input logic [3:0] i, output logic [31:0] d, output logic v);
        @(negedge app_clk);
        rd_idx = i;
        #1;
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic check_entry(string req, logic [3:0] i);
        logic [31:0] d;
        logic        v;
        read_entry(i, d, v);
        chk(req, {31'd0, v, d}, {31'd0, exp_vld[i], exp_data[i]});
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 16; i++) check_entry(req, 4'(i));
    endtask

    task automatic ctl_update(logic [3:0] i, logic [31:0] d);
        @(negedge src_clk);
        src_idx = i; src_data = d; src_ctl_tgl = ~src_ctl_tgl;
        exp_data[i] = d; exp_vld[i] = 1'b1;
        repeat (8) @(negedge src_clk);
    endtask

    task automatic sts_update(logic [52:0] w);
        @(negedge src_clk);
        src_sts = w; src_sts_tgl = ~src_sts_tgl;
        exp_sts = w;
        repeat (8) @(negedge src_clk);
    endtask

    // expected field extraction from the R6 bit map
    function automatic logic [63:0] exp_field(int f, logic [52:0] w);
        case (f)
            0: return 64'(w[52:49]);
            1: return 64'(w[48]);
            2: return 64'(w[47]);
            3: return 64'(w[46:31]);
            4: return 64'(w[30]);
            5: return 64'(w[29:24]);
            6: return 64'(w[23:6]);
            default: return 64'(w[5:0]);
        endcase
    endfunction

    task automatic check_status(string req);
        #1;
        chk(req, 64'(sts_word), 64'(exp_sts));
        chk({req, " R6 err_rpt_en"}, 64'(sts_err_rpt_en), exp_field(0, exp_sts));
        chk({req, " R6 dll_chg"},    64'(sts_dll_chg),    exp_field(1, exp_sts));
        chk({req, " R6 cmd_done"},   64'(sts_cmd_done),   exp_field(2, exp_sts));
        chk({req, " R6 link"},       64'(sts_link),       exp_field(3, exp_sts));
        chk({req, " R6 deemph"},     64'(sts_deemph),     exp_field(4, exp_sts));
        chk({req, " R6 prim_err"},   64'(sts_prim_err),   exp_field(5, exp_sts));
        chk({req, " R6 pme"},        64'(sts_pme),        exp_field(6, exp_sts));
        chk({req, " R6 sec_err"},    64'(sts_sec_err),    exp_field(7, exp_sts));
    endtask

    initial begin
        #(400_000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0047));
        for (int i = 0; i < 16; i++) begin exp_data[i] = '0; exp_vld[i] = 1'b0; end
        exp_sts = '0;

        // timing premise: sync + detect + write within half the hold window
        chk("ratio", 64'((SYNC + 2) * 2 * APP_HALF * 2 <= 8 * 2 * SRC_HALF), 64'd1);

        repeat (5) @(negedge src_clk);
        src_rst_n = 1; app_rst_n = 1;
        repeat (4) @(negedge src_clk);

        // R1 reset state
        check_all("R1 reset entry");
        check_status("R1 reset status");

        // R2 boundary indices, both toggle directions
        ctl_update(4'd0, 32'hDEAD_BEEF);
        check_entry("R2 idx0 rise", 4'd0);
        ctl_update(4'd15, 32'hFFFF_FFFF);
        check_entry("R2 idx15 fall", 4'd15);
        check_all("R3 untouched after boundary writes");

        // R2/R3/R4 random stream
        for (int n = 0; n < 60; n++) begin
            logic [3:0]  i = 4'($urandom_range(0, 15));
            logic [31:0] d = $urandom;
            logic [3:0]  o = 4'($urandom_range(0, 15));
            ctl_update(i, d);
            check_entry("R2 random write", i);
            check_entry("R3 R4 random other", o);
        end
        check_status("R8 status untouched by control");

        // R4 back-to-back read index changes in consecutive cycles
        for (int i = 0; i < 16; i++) check_entry("R4 sweep", 4'(15 - i));

        // R7 data changes without qualifier change
        @(negedge src_clk);
        src_idx = 4'd3; src_data = ~exp_data[3];
        src_sts = ~exp_sts;
        repeat (16) @(negedge src_clk);
        check_entry("R7 no toggle entry", 4'd3);
        check_status("R7 no toggle status");

        // R5/R6 status stream with directed single-field patterns
        sts_update(53'h1 << 52);
        check_status("R5 corr enable");
        sts_update(53'h1 << 30);
        check_status("R5 deemph");
        sts_update(53'h1F_FFFF_FFFF_FFFF);
        check_status("R5 all ones");
        for (int n = 0; n < 20; n++) begin
            sts_update(53'({$urandom, $urandom}));
            check_status("R5 random");
        end
        check_all("R8 shadow untouched by status");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule